// File: doc/BRIEF.md
# RDS Demodulation Phase Selector

This block decides whether the RDS data slicer reads the in-phase or the quadrature product of the recovered 57 kHz carrier. Each incoming symbol sample carries two sign bits: one from the in-phase (0°) detector and one from the quadrature (90°) detector. The block forwards one of the two as the data bit. An external detector reports whether an ARI subcarrier is present. In automatic mode the block follows that report: 0° when ARI is judged present and 90° when it is judged absent. In fixed mode a preference bit pins the phase and the ARI report is ignored.

The ARI report must hold the same value for a programmable number of consecutive accepted samples before it is taken as a judgement. Until a judgement exists, and again after each synchronization reset, the automatic mode uses the phase given by the preference bit. The phase register changes only on an accepted sample, so a symbol is never sliced partly at one phase and partly at the other. Samples enter through a valid/ready handshake. Bits leave through a one-entry valid/ready output stage. An input sample is accepted only when the output stage is empty or is being drained in the same cycle. While the output is stalled the held bit stays unchanged and no sample is taken.

Top module: `rds_phase_sel`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and phase_90 is 0 (0° selected). This matches the preference bit's reset value of 1.
- R2: For each accepted sample (in_valid and in_ready high at a rising edge), out_bit becomes in_q if phase_90 was 1 before that edge, or in_i if it was 0. out_valid is 1 after that edge.
- R3: With cfg_fixed = 1, every accepted sample sets phase_90 to the inverse of cfg_pref (pref 1 gives 0°, pref 0 gives 90°). ari_det has no effect on the phase.
- R4: With cfg_fixed = 0 and no ARI judgement formed, each accepted sample sets phase_90 to the inverse of cfg_pref.
- R5: An ARI judgement forms when ari_det keeps one value for cfg_hold consecutive accepted samples. A cfg_hold of 0 counts as 1. A shorter run changes nothing. From the next accepted sample on, automatic mode selects 0° for a present judgement (ari_det = 1) and 90° for an absent one.
- R6: A sync_rst pulse discards the ARI judgement and the run count. The next accepted sample loads the phase given by cfg_pref, and automatic tracking continues from there.
- R7: phase_90 changes only at a rising edge where a sample is accepted. A sync_rst pulse on its own leaves phase_90 unchanged.
- R8: When out_valid = 1 and out_ready = 0, in_ready is 0, and out_valid and out_bit hold their values in the next cycle.
- R9: Each accepted sample yields exactly one output bit. When out_ready = 1 and no sample is accepted, out_valid falls to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample can be accepted |
| in_i | input | 1 | Sign of the in-phase product |
| in_q | input | 1 | Sign of the quadrature product |
| ari_det | input | 1 | ARI presence report from the external detector |
| sync_rst | input | 1 | Synchronization-reset pulse |
| cfg_fixed | input | 1 | 1 = phase pinned by cfg_pref, 0 = automatic |
| cfg_pref | input | 1 | Preferred phase: 1 = 0°, 0 = 90° |
| cfg_hold | input | CNT_W | Consecutive samples needed for an ARI judgement |
| out_valid | output | 1 | Data bit present |
| out_ready | input | 1 | Consumer takes the bit |
| out_bit | output | 1 | Sliced data bit |
| phase_90 | output | 1 | Current phase: 1 = 90°, 0 = 0° |

## Verification
The hardest case to reach is the gap between an ARI judgement forming and the phase actually moving. The judgement lands on one accepted sample, the phase register moves on the following one, and the first bit sliced at the new phase comes one sample after that. A single-sample glitch of ari_det in the middle of a run must also reset the count. The stimulus table therefore feeds runs of ari_det that are shorter than, equal to and longer than cfg_hold, sample by sample, and checks both the bit and the phase after every accepted sample. Directed sequences then combine a sync_rst pulse with a changed preference, a cfg_hold of zero, and a stalled output while a new sample waits.

// File: rtl/rds_phase_pkg.sv
package rds_phase_pkg;

  typedef enum logic {
    PH_0  = 1'b0,
    PH_90 = 1'b1
  } phase_e;

  // preference 1 asks for 0 degrees, preference 0 for 90 degrees
  function automatic phase_e pref_phase(input logic pref);
    return pref ? PH_0 : PH_90;
  endfunction

endpackage

// File: rtl/ari_debounce.sv
module ari_debounce #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             clr,
  input  logic             ari,
  input  logic [CNT_W-1:0] hold,
  output logic             known,
  output logic             present
);

  logic [CNT_W-1:0] eff_hold;
  logic [CNT_W-1:0] run_q, run_nxt;
  logic             last_q;

  assign eff_hold = (hold == '0) ? CNT_W'(1) : hold;

  always_comb begin
    if (ari != last_q || run_q == '0)
      run_nxt = CNT_W'(1);
    else if (run_q < eff_hold)
      run_nxt = run_q + CNT_W'(1);
    else
      run_nxt = run_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      last_q  <= 1'b0;
      known   <= 1'b0;
      present <= 1'b0;
    end else if (clr) begin
      run_q   <= '0;
      last_q  <= 1'b0;
      known   <= 1'b0;
      present <= 1'b0;
    end else if (fire) begin
      run_q  <= run_nxt;
      last_q <= ari;
      if (run_nxt >= eff_hold) begin
        known   <= 1'b1;
        present <= ari;
      end
    end
  end

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import rds_phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   sync_rst,
  input  logic   fixed,
  input  logic   pref,
  input  logic   known,
  input  logic   present,
  output phase_e phase
);

  phase_e target;

  always_comb begin
    if (fixed || sync_rst || !known)
      target = pref_phase(pref);
    else
      target = present ? PH_0 : PH_90;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= PH_0;
    else if (fire)
      phase <= target;
  end

endmodule

// File: rtl/symbol_slicer.sv
module symbol_slicer
  import rds_phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   out_ready,
  input  phase_e phase,
  input  logic   i_sign,
  input  logic   q_sign,
  output logic   out_valid,
  output logic   out_bit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_bit   <= (phase == PH_90) ? q_sign : i_sign;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rds_phase_sel.sv
module rds_phase_sel
  import rds_phase_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_i,
  input  logic             in_q,
  input  logic             ari_det,
  input  logic             sync_rst,
  input  logic             cfg_fixed,
  input  logic             cfg_pref,
  input  logic [CNT_W-1:0] cfg_hold,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             phase_90
);

  logic   fire;
  logic   ari_known, ari_present;
  phase_e phase;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign phase_90 = (phase == PH_90);

  ari_debounce #(.CNT_W(CNT_W)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .clr     (sync_rst),
    .ari     (ari_det),
    .hold    (cfg_hold),
    .known   (ari_known),
    .present (ari_present)
  );

  phase_ctrl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .sync_rst (sync_rst),
    .fixed    (cfg_fixed),
    .pref     (cfg_pref),
    .known    (ari_known),
    .present  (ari_present),
    .phase    (phase)
  );

  symbol_slicer u_slc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .out_ready (out_ready),
    .phase     (phase),
    .i_sign    (in_i),
    .q_sign    (in_q),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

endmodule

// File: rtl/rds_phase_sel_chk.sv
module rds_phase_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_i,
  input logic in_q,
  input logic cfg_fixed,
  input logic cfg_pref,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic phase_90
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  bit_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && (out_bit == ($past(phase_90) ? $past(in_q) : $past(in_i))));

  // R3
  fixed_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cfg_fixed |=> phase_90 == !$past(cfg_pref));

  // R7
  phase_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(phase_90));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !acc |=> !out_valid);

endmodule

bind rds_phase_sel rds_phase_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_i      (in_i),
  .in_q      (in_q),
  .cfg_fixed (cfg_fixed),
  .cfg_pref  (cfg_pref),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .phase_90  (phase_90)
);

// File: tb/sim_rds_phase_sel.sv
module sim_rds_phase_sel;

  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, in_i, in_q, ari_det, sync_rst;
  logic cfg_fixed, cfg_pref, out_valid, out_ready, out_bit, phase_90;
  logic [CNT_W-1:0] cfg_hold;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  rds_phase_sel #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .ari_det(ari_det), .sync_rst(sync_rst),
    .cfg_fixed(cfg_fixed), .cfg_pref(cfg_pref), .cfg_hold(cfg_hold),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .phase_90(phase_90)
  );

  // fields: fixed, pref, ari, i, q, expected bit, expected phase_90 after
  localparam logic [6:0] VEC [0:13] = '{
    7'b0101010, 7'b0100100, 7'b0100101, 7'b0100111,
    7'b0111001, 7'b0101001, 7'b0111111, 7'b0111001,
    7'b0111000, 7'b0111010, 7'b1010101, 7'b1010111,
    7'b1101000, 7'b0110100
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one sample for one edge; checks happen at the following negedge
  task automatic send(input logic i, input logic q, input logic a);
    @(negedge clk);
    in_valid = 1'b1; in_i = i; in_q = q; ari_det = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_rst = 1'b1;
    @(negedge clk);
    sync_rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = 1'b0; in_q = 1'b0; ari_det = 1'b0;
    sync_rst = 1'b0; cfg_fixed = 1'b0; cfg_pref = 1'b1; cfg_hold = 4'd2;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 phase_90", phase_90, 0);

    // table: R2 bit choice, R3 fixed, R4 undecided, R5 debounce
    for (int k = 0; k < 14; k++) begin
      cfg_fixed = VEC[k][6];
      cfg_pref  = VEC[k][5];
      send(VEC[k][3], VEC[k][2], VEC[k][4]);
      check($sformatf("R2 bit v%0d", k), out_bit, VEC[k][1]);
      check($sformatf("R2 valid v%0d", k), out_valid, 1);
      check($sformatf("R3/R4/R5 phase v%0d", k), phase_90, VEC[k][0]);
    end
    @(negedge clk);
    check("R9 drained", out_valid, 0);

    // R6: judgement present, phase 0; preference now 0 (90 deg)
    cfg_fixed = 1'b0; cfg_pref = 1'b0;
    pulse_sync();
    check("R7 sync alone keeps phase", phase_90, 0);
    send(1'b0, 1'b0, 1'b1);
    check("R6 pref phase after sync", phase_90, 1);
    send(1'b0, 1'b0, 1'b1);
    check("R6 still pref while judging", phase_90, 1);
    send(1'b0, 1'b0, 1'b1);
    check("R5 present after hold", phase_90, 0);

    // R5: hold of zero behaves as one
    cfg_hold = '0; cfg_pref = 1'b1;
    pulse_sync();
    send(1'b0, 1'b0, 1'b0);
    check("R5 hold0 first sample", phase_90, 0);
    send(1'b0, 1'b0, 1'b0);
    check("R5 hold0 absent judged", phase_90, 1);

    // R8 back-pressure, phase is 90 deg
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_i = 1'b0; in_q = 1'b1;
    @(negedge clk);
    in_i = 1'b1; in_q = 1'b0;
    check("R8 first bit", out_bit, 1);
    check("R8 in_ready low", in_ready, 0);
    repeat (2) @(negedge clk);
    check("R8 held bit", out_bit, 1);
    check("R8 held valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second bit", out_bit, 0);
    check("R9 second valid", out_valid, 1);
    @(negedge clk);
    check("R9 no duplicate", out_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule